// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This unit keeps the control and status state that sits beside a floating-point datapath. Software programs a control word that holds a trap-enable byte, a rounding-direction field and a result-precision field. After every completed arithmetic operation, the unit records four things: the exception bits raised by that operation, the result classification flags, an optional quotient byte, and a sticky summary of all exceptions seen since software last cleared it.

A trap request is raised when any exception of the operation just completed is also enabled. It stays up until the trap handler acknowledges it. The operation pipeline runs apart from the processor, so the unit also captures the instruction address of each issued operation. A handler can read that address back later to find the instruction that faulted. All state can be read through one combinational read port and written through one write port.

Top module: `fpsc_unit`

## Requirements
- R1: After reset, every output is zero: mode fields, enable byte, condition nibble, quotient, both exception bytes, instruction address and trap request.
- R2: A write with `wr_sel`=0 loads the enable byte from bits 15:8 and the mode nibble from bits 7:4. Bits 7:6 are precision (00 extended, 01 single, 10 double) and bits 5:4 are rounding (00 nearest, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity). A control read returns bits 3:0 and 31:16 as zero.
- R3: On each `op_done`, the exception byte is replaced by `op_exc`. Its bit order from 7 to 0 is: branch-unordered, signalling NaN, operand error, overflow, underflow, divide by zero, inexact result, inexact input.
- R4: On each `op_done`, the accrued byte ORs in a folded summary. Bit 7 is invalid operation (bits 7, 6 or 5 of `op_exc`). Bit 6 is overflow (bit 4). Bit 5 is underflow (bit 3). Bit 4 is divide by zero (bit 2). Bit 3 is inexact (bits 4, 1 or 0). Bits 2:0 stay zero.
- R5: `clr_accr` zeroes the accrued byte. Bits raised by an operation completing in the same cycle are still kept.
- R6: On each `op_done`, the condition nibble takes `op_cc`, where bit 3 means negative, bit 2 zero, bit 1 infinity and bit 0 NaN.
- R7: The quotient byte changes only when `op_done` and `op_quot_we` are both high.
- R8: `trap_req` rises the cycle after an `op_done` whose `op_exc` AND the enable byte is non-zero. It holds until `trap_ack`. A new trap in the same cycle as an acknowledge wins.
- R9: A status write (`wr_sel`=1) takes priority over a same-cycle operation update. The word layout is condition nibble 27:24, quotient 23:16, exception 15:8, accrued 7:3. Accrued bits 2:0 are forced to zero.
- R10: `iaddr` captures `op_pc` on `op_start`. A write with `wr_sel`=2 loads it directly and takes priority.
- R11: Without `op_done`, a status write or `clr_accr`, the `op_exc`, `op_cc` and `op_quot` inputs have no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Operation issued; capture its address |
| op_pc | input | 32 | Address of the issued instruction |
| op_done | input | 1 | Operation completed this cycle |
| op_exc | input | 8 | Exception bits of the completed operation |
| op_cc | input | 4 | Result classification of the completed operation |
| op_quot | input | 8 | Quotient byte from a remainder-type operation |
| op_quot_we | input | 1 | Quotient byte is valid |
| clr_accr | input | 1 | Clear the accrued exception byte |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 status, 2 address |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read target: 0 control, 1 status, 2 address |
| rd_data | output | 32 | Read data (combinational) |
| trap_ack | input | 1 | Trap acknowledge |
| rnd_mode | output | 2 | Rounding direction |
| prec_mode | output | 2 | Result precision |
| exc_en | output | 8 | Trap-enable byte |
| cc | output | 4 | Condition nibble |
| quot | output | 8 | Quotient byte |
| exc_now | output | 8 | Exceptions of the last operation |
| exc_acc | output | 8 | Sticky accrued exceptions |
| trap_req | output | 1 | Trap request |
| iaddr | output | 32 | Address of the last issued operation |

## Verification
The bench targets the fold from eight exception bits to five accrued bits. Overflow must also set inexact. A design that only copied the bits, or dropped that double mapping, would show the wrong accrued byte after an overflow step. It also drives clear and operation, status write and operation, and acknowledge and new trap in the same cycle. A design with the wrong priority would lose freshly raised accrued bits, let an operation overwrite software's status value, or drop a trap that arrived with its acknowledge. Finally, it checks that the quotient holds when its write enable is low and that the trap stays up through idle cycles.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  localparam int WORD_W = 32;
  localparam int EXC_W  = 8;

  typedef enum logic [1:0] {
    SEL_CTL   = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_IADDR = 2'd2,
    SEL_NONE  = 2'd3
  } regsel_e;

  // exception bit positions (priority order fixed by the status layout)
  localparam int X_BSUN  = 7;
  localparam int X_SNAN  = 6;
  localparam int X_OPERR = 5;
  localparam int X_OVFL  = 4;
  localparam int X_UNFL  = 3;
  localparam int X_DZ    = 2;
  localparam int X_INEX2 = 1;
  localparam int X_INEX1 = 0;

  localparam logic [7:0] ACC_MASK = 8'hF8;

  function automatic logic [7:0] fold_accrued(input logic [7:0] e);
    logic [7:0] a;
    a    = '0;
    a[7] = e[X_SNAN] | e[X_OPERR] | e[X_BSUN];
    a[6] = e[X_OVFL];
    a[5] = e[X_UNFL];
    a[4] = e[X_DZ];
    a[3] = e[X_INEX1] | e[X_INEX2] | e[X_OVFL];
    return a;
  endfunction
endpackage

// File: rtl/fpsc_mode_reg.sv
module fpsc_mode_reg
  import fpsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic [WORD_W-1:0] wd,
  output logic [EXC_W-1:0]  en_byte,
  output logic [1:0]        prec,
  output logic [1:0]        rnd
);
  logic [EXC_W-1:0] en_q, en_d;
  logic [3:0]       mode_q, mode_d;

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    if (wr_ctl) begin
      en_d   = wd[15:8];
      mode_d = wd[7:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
    end else if (wr_ctl) begin
      en_q   <= en_d;
      mode_q <= mode_d;
    end
  end

  assign en_byte = en_q;
  assign prec    = mode_q[3:2];
  assign rnd     = mode_q[1:0];
endmodule

// File: rtl/fpsc_status_reg.sv
module fpsc_status_reg
  import fpsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stat,
  input  logic [WORD_W-1:0] wd,
  input  logic              op_done,
  input  logic [EXC_W-1:0]  op_exc,
  input  logic [3:0]        op_cc,
  input  logic [7:0]        op_quot,
  input  logic              op_quot_we,
  input  logic              clr_acc,
  output logic [3:0]        cc,
  output logic [7:0]        quot,
  output logic [EXC_W-1:0]  exc_now,
  output logic [7:0]        exc_acc
);
  logic [3:0]       cc_q, cc_d;
  logic [7:0]       quot_q, quot_d;
  logic [EXC_W-1:0] exc_q, exc_d;
  logic [7:0]       acc_q, acc_d;
  logic             upd;

  assign upd = wr_stat | clr_acc | op_done;

  always_comb begin
    cc_d   = cc_q;
    quot_d = quot_q;
    exc_d  = exc_q;
    acc_d  = acc_q;
    if (wr_stat) begin
      cc_d   = wd[27:24];
      quot_d = wd[23:16];
      exc_d  = wd[15:8];
      acc_d  = wd[7:0] & ACC_MASK;
    end else begin
      if (clr_acc) acc_d = '0;
      if (op_done) begin
        exc_d = op_exc;
        cc_d  = op_cc;
        if (op_quot_we) quot_d = op_quot;
        acc_d = acc_d | fold_accrued(op_exc);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q   <= '0;
      quot_q <= '0;
      exc_q  <= '0;
      acc_q  <= '0;
    end else if (upd) begin
      cc_q   <= cc_d;
      quot_q <= quot_d;
      exc_q  <= exc_d;
      acc_q  <= acc_d;
    end
  end

  assign cc      = cc_q;
  assign quot    = quot_q;
  assign exc_now = exc_q;
  assign exc_acc = acc_q;
endmodule

// File: rtl/fpsc_trap.sv
module fpsc_trap
  import fpsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_done,
  input  logic [EXC_W-1:0] op_exc,
  input  logic [EXC_W-1:0] en_byte,
  input  logic             trap_ack,
  output logic             trap_req
);
  logic trap_q, trap_d, hit, upd;

  assign hit = op_done & (|(op_exc & en_byte));
  assign upd = hit | trap_ack;

  always_comb begin
    trap_d = trap_q;
    if (trap_ack) trap_d = 1'b0;
    if (hit)      trap_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   trap_q <= 1'b0;
    else if (upd) trap_q <= trap_d;
  end

  assign trap_req = trap_q;
endmodule

// File: rtl/fpsc_iaddr.sv
module fpsc_iaddr
  import fpsc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [AW-1:0]     op_pc,
  input  logic              wr_ia,
  input  logic [WORD_W-1:0] wd,
  output logic [AW-1:0]     iaddr
);
  logic [AW-1:0] ia_q, ia_d;
  logic          upd;

  assign upd = op_start | wr_ia;

  always_comb begin
    ia_d = ia_q;
    if (wr_ia)         ia_d = wd[AW-1:0];
    else if (op_start) ia_d = op_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ia_q <= '0;
    else if (upd) ia_q <= ia_d;
  end

  assign iaddr = ia_q;
endmodule

// File: rtl/fpsc_unit.sv
module fpsc_unit
  import fpsc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [AW-1:0]     op_pc,
  input  logic              op_done,
  input  logic [EXC_W-1:0]  op_exc,
  input  logic [3:0]        op_cc,
  input  logic [7:0]        op_quot,
  input  logic              op_quot_we,
  input  logic              clr_accr,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic              trap_ack,
  output logic [1:0]        rnd_mode,
  output logic [1:0]        prec_mode,
  output logic [EXC_W-1:0]  exc_en,
  output logic [3:0]        cc,
  output logic [7:0]        quot,
  output logic [EXC_W-1:0]  exc_now,
  output logic [7:0]        exc_acc,
  output logic              trap_req,
  output logic [AW-1:0]     iaddr
);
  logic wr_ctl, wr_stat, wr_ia;

  assign wr_ctl  = wr_en & (wr_sel == SEL_CTL);
  assign wr_stat = wr_en & (wr_sel == SEL_STAT);
  assign wr_ia   = wr_en & (wr_sel == SEL_IADDR);

  fpsc_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wd(wr_data),
    .en_byte(exc_en), .prec(prec_mode), .rnd(rnd_mode)
  );

  fpsc_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wd(wr_data),
    .op_done(op_done), .op_exc(op_exc), .op_cc(op_cc),
    .op_quot(op_quot), .op_quot_we(op_quot_we), .clr_acc(clr_accr),
    .cc(cc), .quot(quot), .exc_now(exc_now), .exc_acc(exc_acc)
  );

  fpsc_trap u_trap (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_exc(op_exc),
    .en_byte(exc_en), .trap_ack(trap_ack), .trap_req(trap_req)
  );

  fpsc_iaddr #(.AW(AW)) u_ia (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_pc(op_pc),
    .wr_ia(wr_ia), .wd(wr_data), .iaddr(iaddr)
  );

  always_comb begin
    case (rd_sel)
      SEL_CTL:   rd_data = {16'h0, exc_en, prec_mode, rnd_mode, 4'h0};
      SEL_STAT:  rd_data = {4'h0, cc, quot, exc_now, exc_acc};
      SEL_IADDR: rd_data = WORD_W'(iaddr);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/fpsc_unit_chk.sv
module fpsc_unit_chk
  import fpsc_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_start,
  input logic [AW-1:0]     op_pc,
  input logic              op_done,
  input logic [EXC_W-1:0]  op_exc,
  input logic [3:0]        op_cc,
  input logic              clr_accr,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [WORD_W-1:0] wr_data,
  input logic [1:0]        rd_sel,
  input logic [WORD_W-1:0] rd_data,
  input logic              trap_ack,
  input logic [EXC_W-1:0]  exc_en,
  input logic [3:0]        cc,
  input logic [EXC_W-1:0]  exc_now,
  input logic [7:0]        exc_acc,
  input logic              trap_req,
  input logic [AW-1:0]     iaddr
);
  logic sw_stat, sw_ia;
  assign sw_stat = wr_en && (wr_sel == SEL_STAT);
  assign sw_ia   = wr_en && (wr_sel == SEL_IADDR);

  a_r2_ctl_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_CTL) |-> (rd_data[3:0] == 4'h0 && rd_data[31:16] == 16'h0));

  a_r3_exc_replaced: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !sw_stat) |=> exc_now == $past(op_exc));

  a_r6_cc_replaced: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !sw_stat) |=> cc == $past(op_cc));

  a_r4_acc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_accr && !sw_stat) |=> ((exc_acc & $past(exc_acc)) == $past(exc_acc)));

  a_r4_acc_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    exc_acc[2:0] == 3'b000);

  a_r8_trap_set: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && (|(op_exc & exc_en))) |=> trap_req);

  a_r8_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !trap_ack) |=> trap_req);

  a_r9_stat_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stat |=> (cc == $past(wr_data[27:24]) && exc_now == $past(wr_data[15:8])));

  a_r10_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !sw_ia) |=> iaddr == $past(op_pc));

  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_done && !sw_stat && !clr_accr) |=> ($stable(exc_now) && $stable(cc) && $stable(exc_acc)));
endmodule

bind fpsc_unit fpsc_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_pc(op_pc),
  .op_done(op_done), .op_exc(op_exc), .op_cc(op_cc), .clr_accr(clr_accr),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
  .rd_data(rd_data), .trap_ack(trap_ack), .exc_en(exc_en), .cc(cc),
  .exc_now(exc_now), .exc_acc(exc_acc), .trap_req(trap_req), .iaddr(iaddr)
);

// File: tb/fpsc_unit_tb.sv
module fpsc_unit_tb;
  logic        clk, rst_n;
  logic        op_start, op_done, op_quot_we, clr_accr, wr_en, trap_ack;
  logic [31:0] op_pc, wr_data, rd_data, iaddr;
  logic [7:0]  op_exc, op_quot, exc_en, quot, exc_now, exc_acc;
  logic [3:0]  op_cc, cc;
  logic [1:0]  wr_sel, rd_sel, rnd_mode, prec_mode;
  logic        trap_req;

  int total = 0;
  int bad   = 0;

  fpsc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_pc(op_pc),
    .op_done(op_done), .op_exc(op_exc), .op_cc(op_cc), .op_quot(op_quot),
    .op_quot_we(op_quot_we), .clr_accr(clr_accr), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .trap_ack(trap_ack), .rnd_mode(rnd_mode), .prec_mode(prec_mode),
    .exc_en(exc_en), .cc(cc), .quot(quot), .exc_now(exc_now),
    .exc_acc(exc_acc), .trap_req(trap_req), .iaddr(iaddr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {exc, cc, expected accrued (cumulative), expected trap} with enable = overflow only
  localparam int NV = 6;
  localparam logic [20:0] VEC [NV] = '{
    {8'h01, 4'h0, 8'h08, 1'b0},
    {8'h04, 4'h4, 8'h18, 1'b0},
    {8'h10, 4'h2, 8'h58, 1'b1},
    {8'h40, 4'h1, 8'hD8, 1'b0},
    {8'h08, 4'h8, 8'hF8, 1'b0},
    {8'h00, 4'hC, 8'hF8, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_start = 0; op_done = 0; op_quot_we = 0; clr_accr = 0;
    wr_en = 0; trap_ack = 0; op_exc = 0; op_cc = 0; op_quot = 0;
    op_pc = 0; wr_sel = 0; wr_data = 0;
  endtask

  // drive one cycle of stimulus at a falling edge, release at the next falling edge
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step();
  endtask

  task automatic op(input logic [7:0] e, input logic [3:0] c);
    @(negedge clk);
    op_done = 1; op_exc = e; op_cc = c;
    step();
  endtask

  initial begin
    rst_n = 0;
    rd_sel = 2'd1;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 status", rd_data, 32'h0);
    check("R1 trap", {31'h0, trap_req}, 32'h0);
    check("R1 iaddr", iaddr, 32'h0);
    check("R1 mode", {24'h0, exc_en, prec_mode, rnd_mode, 4'h0}, 32'h0);

    // R2 control write: enable=overflow, prec=10 double, rnd=11 plus infinity
    reg_write(2'd0, 32'hFFFF_10BF);
    rd_sel = 2'd0; #1;
    check("R2 ctl read", rd_data, 32'h0000_10B0);
    check("R2 prec", {30'h0, prec_mode}, 32'h2);
    check("R2 rnd", {30'h0, rnd_mode}, 32'h3);
    rd_sel = 2'd1;

    // R3 R4 R6 R8 table walk
    for (int i = 0; i < NV; i++) begin
      op(VEC[i][20:13], VEC[i][12:9]);
      check("R3 exc byte", {24'h0, exc_now}, {24'h0, VEC[i][20:13]});
      check("R6 cc", {28'h0, cc}, {28'h0, VEC[i][12:9]});
      check("R4 accrued", {24'h0, exc_acc}, {24'h0, VEC[i][8:1]});
      check("R8 trap", {31'h0, trap_req}, {31'h0, VEC[i][0]});
      if (trap_req) begin
        @(negedge clk); trap_ack = 1; step();
        check("R8 ack clears", {31'h0, trap_req}, 32'h0);
      end
    end

    // R7 quotient
    @(negedge clk); op_done = 1; op_quot_we = 1; op_quot = 8'h5A; step();
    check("R7 quot load", {24'h0, quot}, 32'h5A);
    @(negedge clk); op_done = 1; op_quot_we = 0; op_quot = 8'h33; step();
    check("R7 quot held", {24'h0, quot}, 32'h5A);

    // R5 clear alone, then clear with same-cycle inexact2
    @(negedge clk); clr_accr = 1; step();
    check("R5 clear", {24'h0, exc_acc}, 32'h0);
    op(8'h08, 4'h0);
    @(negedge clk); clr_accr = 1; op_done = 1; op_exc = 8'h02; step();
    check("R5 clear+op", {24'h0, exc_acc}, 32'h08);

    // R8 hold through idle, ack, ack with new trap
    op(8'h10, 4'h0);
    step(); step();
    check("R8 held", {31'h0, trap_req}, 32'h1);
    @(negedge clk); trap_ack = 1; op_done = 1; op_exc = 8'h10; step();
    check("R8 ack+new", {31'h0, trap_req}, 32'h1);
    @(negedge clk); trap_ack = 1; step();
    check("R8 ack", {31'h0, trap_req}, 32'h0);

    // R9 status write beats operation
    @(negedge clk); wr_en = 1; wr_sel = 2'd1; wr_data = 32'h0312_0047;
    op_done = 1; op_exc = 8'h01; op_cc = 4'h8; step();
    check("R9 status", rd_data, 32'h0312_0040);

    // R11 inputs without completion ignored
    @(negedge clk); op_exc = 8'hFF; op_cc = 4'hF; op_quot = 8'hEE; step();
    check("R11 status", rd_data, 32'h0312_0040);

    // R10 address capture and write
    @(negedge clk); op_start = 1; op_pc = 32'h0000_1234; step();
    check("R10 capture", iaddr, 32'h0000_1234);
    op(8'h00, 4'h0);
    check("R10 held", iaddr, 32'h0000_1234);
    @(negedge clk); op_start = 1; op_pc = 32'h5555_0000;
    wr_en = 1; wr_sel = 2'd2; wr_data = 32'hABCD_0010; step();
    rd_sel = 2'd2; #1;
    check("R10 write wins", rd_data, 32'hABCD_0010);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule